// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a compact in-order processor pipeline. Work moves through fetch, decode, operand read, execute and write-back, with a register bank between each pair of stages. One new instruction starts every cycle, and the fetch address simply advances by one. The instruction set is deliberately tiny: add, subtract, a jump taken when the last arithmetic result was zero, an unconditional jump, and a no-operation. Every instruction has the same fixed latency.

Two mechanisms keep the pipeline correct without stalling. First, when a source operand names the destination of an instruction one or two places ahead, the operand is taken from a bypass and not from the register file. The compare that decides this is made as soon as the dependent instruction is decoded. Second, a taken jump is resolved in execute. The three younger instructions already in flight are turned into bubbles, and fetch restarts at the target.

The program store is written through a load port. The register file can be preset through an initialisation port, but only while reset is held. Each completed register write is reported on a retire strobe, together with its destination and value.

Top module: `pipe5_core`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0, empties every pipeline stage to a no-operation and clears the zero flag. Retire stays low during reset. After release, the instruction at address 0 retires in the fourth cycle.
- R2: Instructions are 16 bits wide. The opcode is in [15:12]: 0 no-op, 1 add, 2 subtract, 3 jump-if-zero, 4 jump. Any other opcode acts as a no-op. Arithmetic uses destination [11:8], first source [7:4] and second source [3:0]. Jumps take their absolute target from [7:0].
- R3: Add and subtract operate on 8-bit values and wrap modulo 256. Register 0 always reads as zero. A write to register 0 is discarded and is not retired, but it still updates the zero flag.
- R4: One instruction is fetched each cycle from the next sequential address. An instruction fetched at edge f retires at edge f+3, so a stream of independent instructions retires one per cycle.
- R5: A source that matches the destination of the instruction immediately ahead receives that instruction's execute result, with no stall. Starting from registers 1..5 = 1,2,3,44,55, the pair add r5,r2,r3 then sub r4,r5,r1 retires r5=5 and then r4=4.
- R6: A source that matches the destination of the instruction two places ahead receives the value being written back that cycle. The nearer producer wins when both match.
- R7: Jump-if-zero is taken when the most recent add or subtract produced zero. No-ops and jumps leave the flag unchanged.
- R8: The unconditional jump is always taken, and the fetch address equals its target on the cycle after it executes.
- R9: A taken jump turns the three instructions fetched after it into no-ops, which change no register and never retire. The target is fetched four edges after the jump itself.
- R10: Each add or subtract with a non-zero destination raises the retire strobe for one cycle, with its destination and result, in program order.
- R11: Register preset writes take effect only while reset is asserted. Preset writes made during run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Program store write enable |
| imem_addr | input | AW | Program store write address |
| imem_data | input | 16 | Program store write data |
| rf_init_we | input | 1 | Register preset enable, honoured only in reset |
| rf_init_addr | input | 4 | Register preset index |
| rf_init_data | input | DW | Register preset value |
| ret_valid | output | 1 | An instruction wrote a register this cycle |
| ret_rd | output | 4 | Destination of the retiring instruction |
| ret_data | output | DW | Value written by the retiring instruction |

## Verification
The delicate coincidences are a forward into an instruction that a jump ahead of it is about to squash, and two bypasses that match the same source in the same cycle. Both are provoked by placing dependent arithmetic directly behind and two behind a producer, and by placing producers and a second jump in the shadow of a taken jump. A behavioural instruction-level model in the bench predicts the exact retire cycle, destination and value of every instruction, and the bench compares the retire port against it on every clock. Any forward that is lost, misrouted or applied from a squashed slot therefore shows up as a wrong value or a wrong cycle.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int ILEN = 16;
  localparam int RIDX = 4;
  localparam int TGTW = 8;

  typedef enum logic [3:0] {
    OP_NOP = 4'h0,
    OP_ADD = 4'h1,
    OP_SUB = 4'h2,
    OP_JZ  = 4'h3,
    OP_JMP = 4'h4
  } op_e;

  typedef struct packed {
    op_e             op;
    logic [RIDX-1:0] rd;
    logic [RIDX-1:0] rs1;
    logic [RIDX-1:0] rs2;
    logic [TGTW-1:0] tgt;
  } dec_t;

  localparam dec_t DEC_NOP = dec_t'('0);

  function automatic logic writes_reg(op_e op, logic [RIDX-1:0] rd);
    return ((op == OP_ADD) || (op == OP_SUB)) && (rd != '0);
  endfunction
endpackage

// File: rtl/pipe5_imem.sv
module pipe5_imem #(
  parameter int AW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int DW    = 8,
  parameter int NREG  = 16,
  parameter int NRD   = 2,
  localparam int XW   = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [XW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][XW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  logic [DW-1:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) bank[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : bank[raddr[p]];
  end
endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic            valid,
  input  logic [ILEN-1:0] instr,
  output dec_t            dec
);
  always_comb begin
    dec = DEC_NOP;
    if (valid) begin
      unique case (instr[15:12])
        4'h1, 4'h2: begin
          dec.op  = (instr[15:12] == 4'h1) ? OP_ADD : OP_SUB;
          dec.rd  = instr[11:8];
          dec.rs1 = instr[7:4];
          dec.rs2 = instr[3:0];
        end
        4'h3, 4'h4: begin
          dec.op  = (instr[15:12] == 4'h3) ? OP_JZ : OP_JMP;
          dec.tgt = instr[TGTW-1:0];
        end
        default: dec = DEC_NOP;
      endcase
    end
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          arith
);
  assign arith = (op == OP_ADD) || (op == OP_SUB);
  assign y     = (op == OP_SUB) ? (a - b) : (a + b);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_we,
  input  logic [AW-1:0]   imem_addr,
  input  logic [ILEN-1:0] imem_data,
  input  logic            rf_init_we,
  input  logic [RIDX-1:0] rf_init_addr,
  input  logic [DW-1:0]   rf_init_data,
  output logic            ret_valid,
  output logic [RIDX-1:0] ret_rd,
  output logic [DW-1:0]   ret_data
);
  localparam int NSRC = 2;
  localparam int NREG = 1 << RIDX;

  // fetch
  logic [AW-1:0]   pc_q;
  logic            fd_valid_q;
  logic [ILEN-1:0] fd_instr;

  // decode -> operand read
  dec_t            id_dec;
  dec_t            de_q;
  logic [NSRC-1:0] de_fex_q, de_fwb_q;
  logic [NSRC-1:0] id_fex, id_fwb;
  logic [NSRC-1:0][RIDX-1:0] id_src, rr_src;

  // operand read -> execute
  op_e                     re_op_q;
  logic [RIDX-1:0]         re_rd_q;
  logic [TGTW-1:0]         re_tgt_q;
  logic [NSRC-1:0][DW-1:0] re_opnd_q;
  logic [NSRC-1:0][DW-1:0] rf_rdata, rr_opnd;

  // execute -> write-back
  logic            xw_we_q;
  logic [RIDX-1:0] xw_rd_q;
  logic [DW-1:0]   xw_data_q;
  logic            z_q;

  logic [DW-1:0]   alu_y;
  logic            alu_arith;
  logic            br_taken;

  logic            rf_we;
  logic [RIDX-1:0] rf_waddr;
  logic [DW-1:0]   rf_wdata;

  pipe5_imem #(.AW(AW), .IW(ILEN)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (imem_addr),
    .wdata (imem_data),
    .raddr (pc_q),
    .rdata (fd_instr)
  );

  pipe5_decode u_dec (
    .valid (fd_valid_q),
    .instr (fd_instr),
    .dec   (id_dec)
  );

  // dependence compare right after decode, against the two older slots
  assign id_src = {id_dec.rs2, id_dec.rs1};
  assign rr_src = {de_q.rs2, de_q.rs1};

  for (genvar p = 0; p < NSRC; p++) begin : g_haz
    assign id_fex[p] = writes_reg(de_q.op, de_q.rd) && (id_src[p] == de_q.rd);
    assign id_fwb[p] = writes_reg(re_op_q, re_rd_q) && (id_src[p] == re_rd_q);
    assign rr_opnd[p] = de_fex_q[p] ? alu_y :
                        de_fwb_q[p] ? xw_data_q : rf_rdata[p];
  end

  assign rf_we    = rst ? rf_init_we   : xw_we_q;
  assign rf_waddr = rst ? rf_init_addr : xw_rd_q;
  assign rf_wdata = rst ? rf_init_data : xw_data_q;

  pipe5_regfile #(.DW(DW), .NREG(NREG), .NRD(NSRC)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rr_src),
    .rdata (rf_rdata)
  );

  pipe5_alu #(.DW(DW)) u_alu (
    .op    (re_op_q),
    .a     (re_opnd_q[0]),
    .b     (re_opnd_q[1]),
    .y     (alu_y),
    .arith (alu_arith)
  );

  assign br_taken = (re_op_q == OP_JMP) || ((re_op_q == OP_JZ) && z_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      fd_valid_q <= 1'b0;
      de_q       <= DEC_NOP;
      de_fex_q   <= '0;
      de_fwb_q   <= '0;
      re_op_q    <= OP_NOP;
      re_rd_q    <= '0;
      re_tgt_q   <= '0;
      re_opnd_q  <= '0;
      xw_we_q    <= 1'b0;
      xw_rd_q    <= '0;
      xw_data_q  <= '0;
      z_q        <= 1'b0;
    end else begin
      xw_we_q   <= alu_arith && (re_rd_q != '0);
      xw_rd_q   <= re_rd_q;
      xw_data_q <= alu_y;
      if (alu_arith) z_q <= (alu_y == '0);
      re_opnd_q <= rr_opnd;
      re_tgt_q  <= de_q.tgt;
      if (br_taken) begin
        pc_q       <= re_tgt_q[AW-1:0];
        fd_valid_q <= 1'b0;
        de_q       <= DEC_NOP;
        de_fex_q   <= '0;
        de_fwb_q   <= '0;
        re_op_q    <= OP_NOP;
        re_rd_q    <= '0;
      end else begin
        pc_q       <= pc_q + 1'b1;
        fd_valid_q <= 1'b1;
        de_q       <= id_dec;
        de_fex_q   <= id_fex;
        de_fwb_q   <= id_fwb;
        re_op_q    <= de_q.op;
        re_rd_q    <= de_q.rd;
      end
    end
  end

  assign ret_valid = xw_we_q;
  assign ret_rd    = xw_rd_q;
  assign ret_data  = xw_data_q;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
  import pipe5_pkg::*;
#(
  parameter int AW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ret_valid,
  input logic [RIDX-1:0] ret_rd,
  input logic            br_taken,
  input logic [AW-1:0]   br_tgt,
  input logic [AW-1:0]   pc_q,
  input op_e             de_op,
  input op_e             re_op,
  input logic [RIDX-1:0] re_rd
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !ret_valid);

  // R3
  no_zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> (ret_rd != '0));

  // R4
  seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> (pc_q == AW'($past(pc_q) + 1'b1)));

  // R8
  redirect_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc_q == $past(br_tgt)));

  // R9
  flush_slots_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> ((de_op == OP_NOP) && (re_op == OP_NOP)));

  // R9
  shadow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> !ret_valid ##1 !ret_valid ##1 !ret_valid ##1 !ret_valid);

  // R10
  retire_next_chk: assert property (@(posedge clk) disable iff (rst)
    (((re_op == OP_ADD) || (re_op == OP_SUB)) && (re_rd != '0))
      |=> (ret_valid && (ret_rd == $past(re_rd))));
endmodule

bind pipe5_core pipe5_core_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ret_valid (ret_valid),
  .ret_rd    (ret_rd),
  .br_taken  (br_taken),
  .br_tgt    (re_tgt_q[AW-1:0]),
  .pc_q      (pc_q),
  .de_op     (de_q.op),
  .re_op     (re_op_q),
  .re_rd     (re_rd_q)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam logic [3:0] K_NOP = 4'h0, K_ADD = 4'h1, K_SUB = 4'h2,
                         K_JZ = 4'h3, K_JMP = 4'h4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          imem_we = 1'b0;
  logic [AW-1:0] imem_addr = '0;
  logic [15:0]   imem_data = '0;
  logic          rf_init_we = 1'b0;
  logic [3:0]    rf_init_addr = '0;
  logic [DW-1:0] rf_init_data = '0;
  logic          ret_valid;
  logic [3:0]    ret_rd;
  logic [DW-1:0] ret_data;

  always #5 clk = ~clk;

  pipe5_core #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_data(imem_data),
    .rf_init_we(rf_init_we), .rf_init_addr(rf_init_addr), .rf_init_data(rf_init_data),
    .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_data(ret_data)
  );

  int total = 0;
  int bad = 0;
  int cyc;
  logic [15:0] pm [256];
  int plen;
  logic [7:0] rinit [16];
  int q_cyc[$], q_rd[$], q_dat[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [15:0] ia(logic [3:0] op, int rd, int rs1, int rs2);
    return {op, rd[3:0], rs1[3:0], rs2[3:0]};
  endfunction

  function automatic logic [15:0] ij(logic [3:0] op, int t);
    return {op, 4'h0, t[7:0]};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) pm[i] = '0;
    for (int i = 0; i < 16; i++) rinit[i] = '0;
    plen = 0;
  endtask

  task automatic put(logic [15:0] w);
    pm[plen] = w;
    plen++;
  endtask

  // behavioural instruction-level model with retire timing
  task automatic model(output int last_f);
    logic [7:0] r [16];
    logic [7:0] v;
    logic [15:0] w;
    int pc = 0, f = 1, steps = 0;
    bit z = 0;
    for (int i = 0; i < 16; i++) r[i] = rinit[i];
    r[0] = '0;
    q_cyc.delete(); q_rd.delete(); q_dat.delete();
    while (pc < plen && steps < 400) begin
      w = pm[pc];
      steps++;
      case (w[15:12])
        K_ADD, K_SUB: begin
          v = (w[15:12] == K_ADD) ? r[w[7:4]] + r[w[3:0]] : r[w[7:4]] - r[w[3:0]];
          z = (v == 0);
          if (w[11:8] != 0) begin
            r[w[11:8]] = v;
            q_cyc.push_back(f + 3); q_rd.push_back(int'(w[11:8])); q_dat.push_back(int'(v));
          end
          pc++; f++;
        end
        K_JZ, K_JMP: begin
          if (w[15:12] == K_JMP || z) begin pc = int'(w[7:0]); f += 4; end
          else begin pc++; f++; end
        end
        default: begin pc++; f++; end
      endcase
    end
    last_f = f;
  endtask

  task automatic run(string tag, bit poke);
    int last_f;
    model(last_f);
    rst = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      imem_we = 1'b1; imem_addr = AW'(a); imem_data = pm[a];
      @(negedge clk);
    end
    imem_we = 1'b0;
    for (int i = 1; i < 16; i++) begin
      rf_init_we = 1'b1; rf_init_addr = 4'(i); rf_init_data = rinit[i];
      @(negedge clk);
    end
    rf_init_we = 1'b0;
    cyc = 0;
    check(ret_valid == 1'b0, "R1", "retire during reset", int'(ret_valid), 0);
    rst = 1'b0;
    while (cyc < last_f + 8) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        check(ret_valid == 1'b1, tag, "retire strobe", int'(ret_valid), 1);
        check(int'(ret_rd) == q_rd[0], tag, "retire dest", int'(ret_rd), q_rd[0]);
        check(int'(ret_data) == q_dat[0], tag, "retire value", int'(ret_data), q_dat[0]);
        void'(q_cyc.pop_front()); void'(q_rd.pop_front()); void'(q_dat.pop_front());
      end else begin
        check(ret_valid == 1'b0, tag, "unexpected retire", int'(ret_valid), 0);
      end
      rf_init_we   = poke && (cyc >= 1) && (cyc < 6);
      rf_init_addr = 4'd1;
      rf_init_data = 8'd99;
    end
    rf_init_we = 1'b0;
    check(q_cyc.size() == 0, tag, "missing retires", q_cyc.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL R4 watchdog expired: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R5 R10 R2 R1: adjacent dependence, retire order, first retire in cycle 4
    clear_prog();
    rinit[1] = 1; rinit[2] = 2; rinit[3] = 3; rinit[4] = 44; rinit[5] = 55;
    put(ia(K_ADD, 5, 2, 3));
    put(ia(K_SUB, 4, 5, 1));
    run("R5 R10 R2 R1", 1'b0);

    // R6: two-apart bypass, both bypasses on one instruction, nearer wins
    clear_prog();
    for (int i = 1; i < 16; i++) rinit[i] = 8'(3 * i + 1);
    put(ia(K_ADD, 6, 1, 2));
    put(ia(K_ADD, 7, 3, 3));
    put(ia(K_SUB, 8, 6, 1));
    put(ia(K_ADD, 9, 8, 8));
    put(ia(K_ADD, 10, 9, 8));
    put(ia(K_ADD, 10, 10, 10));
    put(ia(K_SUB, 11, 10, 10));
    put(ia(K_SUB, 12, 10, 6));
    run("R6", 1'b0);

    // R3: wrap-around, register 0 reads zero, write to it discarded
    clear_prog();
    rinit[1] = 200; rinit[2] = 100;
    put(ia(K_ADD, 3, 1, 2));
    put(ia(K_SUB, 4, 2, 1));
    put(ia(K_ADD, 0, 1, 1));
    put(ia(K_ADD, 5, 0, 1));
    put(ia(K_SUB, 6, 0, 2));
    put(16'hF123);
    put(ia(K_ADD, 7, 0, 0));
    run("R3 R2", 1'b0);

    // R7 R9: taken and not-taken conditional jumps, flag held across no-op
    clear_prog();
    rinit[1] = 5; rinit[2] = 5; rinit[3] = 7;
    put(ia(K_SUB, 4, 1, 2));   // 0: zero
    put(ij(K_JZ, 8));          // 1: taken
    put(ia(K_ADD, 5, 1, 1));   // 2: shadow
    put(ia(K_ADD, 5, 3, 3));   // 3: shadow
    put(ia(K_ADD, 12, 1, 1));  // 4: shadow
    put(16'h0000); put(16'h0000); put(16'h0000);
    put(ia(K_ADD, 6, 1, 3));   // 8
    put(ia(K_SUB, 7, 3, 1));   // 9: nonzero
    put(ij(K_JZ, 2));          // 10: not taken
    put(ia(K_ADD, 8, 7, 7));   // 11
    put(ia(K_SUB, 0, 1, 2));   // 12: zero, discarded
    put(16'h0000);             // 13
    put(ij(K_JZ, 17));         // 14: taken
    put(ia(K_ADD, 10, 1, 1));  // 15: shadow
    put(ia(K_ADD, 10, 3, 1));  // 16: shadow
    put(ia(K_ADD, 11, 4, 6));  // 17
    run("R7 R9", 1'b0);

    // R8 R9: unconditional jumps, a jump inside another jump's shadow
    clear_prog();
    rinit[2] = 3;
    put(ia(K_ADD, 1, 2, 2));   // 0
    put(ij(K_JMP, 5));         // 1
    put(ia(K_ADD, 3, 2, 2));   // 2: shadow
    put(ia(K_ADD, 3, 1, 1));   // 3: shadow
    put(ij(K_JMP, 0));         // 4: shadow
    put(ij(K_JMP, 7));         // 5
    put(ia(K_ADD, 9, 1, 1));   // 6: shadow
    put(ia(K_SUB, 4, 1, 2));   // 7
    put(ij(K_JMP, 10));        // 8
    put(ij(K_JMP, 0));         // 9: shadow
    put(ia(K_ADD, 5, 4, 1));   // 10
    run("R8 R9", 1'b0);

    // R11 R4: preset writes during run ignored; back-to-back throughput
    clear_prog();
    rinit[1] = 1;
    for (int i = 0; i < 6; i++) put(16'h0000);
    put(ia(K_ADD, 2, 1, 1));
    for (int k = 3; k < 12; k++) put(ia(K_ADD, k, 1, 1));
    run("R11 R4", 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule